// File: doc/BRIEF.md
# Slave-Port Master Arbiter

This block chooses which of seven bus masters owns one slave port of a multi-master crossbar. Each master raises a request line. The arbiter grants the port to one master at a time and shows the winner as a one-hot vector and as a binary ID. The winner keeps the port for as long as it holds its request.

A run-time mode input selects the arbitration policy. The first policy is a fair rotation that starts its search after the most recently granted master. The second is a fixed order in which software gives each master a 3-bit priority value. In either policy, a per-master elevate input lets a master go ahead of every master that is not elevated, for as long as the input is held.

Address decoding, data-path steering and bus protocol handling are done by the surrounding crossbar.

Top module: `slave_port_arbiter`

## Requirements
- R1: `grant_o` has at most one bit set, where bit i stands for master i. Whenever `grant_valid_o` is high, `grant_id_o` holds the index of the set bit. When there is no grant, `grant_o` and `grant_id_o` are both zero.
- R2: Arbitration uses the requests sampled at a rising clock edge, and the resulting grant appears just after that edge. A master is only granted if it was requesting at that edge.
- R3: While the granted master keeps its request high, the grant does not change, whatever the other requests or elevate inputs do.
- R4: With `mode_fixed_i` low (rotation), the new winner is the first requesting candidate found by searching upward from the ID after the last granted master, wrapping from 6 back to 0.
- R5: After reset there is no grant, and the last-granted ID is 6. So with every master requesting, the first rotation grant goes to master 0.
- R6: With `mode_fixed_i` high, the requesting candidate with the largest priority value wins. Master i's value is `prio_cfg_i[3*i+2:3*i]`.
- R7: In fixed mode, when candidates have equal values, the lowest master ID wins.
- R8: A master with both its request and its `elev_i` bit high beats every master that is not elevated. Among elevated masters, the rules of the current mode decide.
- R9: A change to `mode_fixed_i` or `prio_cfg_i` during a held grant has no effect until the next arbitration point, where it applies.
- R10: When no master requests at an arbitration point, the port goes idle: `grant_valid_o` is low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 7 | Per-master request |
| elev_i | input | 7 | Per-master temporary priority elevation |
| mode_fixed_i | input | 1 | 0 = rotation, 1 = programmed fixed priority |
| prio_cfg_i | input | 21 | Packed 3-bit priority per master |
| grant_o | output | 7 | One-hot grant |
| grant_id_o | output | 3 | Binary ID of the granted master |
| grant_valid_o | output | 1 | A grant is active |

## Verification
The bench drives a rotation that wraps from a high ID back to master 0. A search that does not take the modulo would either grant nothing or grant the wrong master at that point.

It checks a tie in fixed priority, where a wrong comparison direction would hand the port to the higher ID. It checks an elevated master whose programmed value is lowest; a design that only ORs in the elevation would let the high-value master win.

It also switches the mode and the priority values during a held grant. A design that re-arbitrates on configuration changes would take the port away from the current owner.

Finally, it makes the first grant after reset with every master requesting. A wrong reset value for the last-granted ID would make that grant go somewhere other than master 0.

// File: rtl/arb_pkg.sv
// Package: shared sizing constants for the slave-port arbiter.
package arb_pkg;
    localparam int NUM_MASTERS = 7;
    localparam int PRIO_W      = 3;
    localparam int ID_W        = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
endpackage

// File: rtl/arb_rr_pick.sv
// Module: arb_rr_pick
// Purpose: rotating search over a candidate vector. It returns the first set
//          candidate found after last_i, wrapping modulo N.
// Assumes: last_i < N. The output is only meaningful when cand_i is non-zero.
module arb_rr_pick #(
    parameter int N    = arb_pkg::NUM_MASTERS,
    parameter int ID_W = arb_pkg::ID_W
) (
    input  logic [N-1:0]    cand_i,
    input  logic [ID_W-1:0] last_i,
    output logic [ID_W-1:0] pick_o
);
    // Walk the offsets from the farthest to the nearest, so the nearest set candidate wins.
    always_comb begin
        pick_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(last_i) + 1 + k) % N;
            if (cand_i[idx]) pick_o = ID_W'(idx);
        end
    end
endmodule

// File: rtl/arb_prio_pick.sv
// Module: arb_prio_pick
// Purpose: picks the candidate with the largest programmed value. On a tie,
//          the lowest index wins.
// Assumes: prio_i packs PRIO_W bits per master, with master 0 in the LSBs.
module arb_prio_pick #(
    parameter int N      = arb_pkg::NUM_MASTERS,
    parameter int PRIO_W = arb_pkg::PRIO_W,
    parameter int ID_W   = arb_pkg::ID_W
) (
    input  logic [N-1:0]        cand_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    output logic [ID_W-1:0]     pick_o
);
    logic              found;
    logic [PRIO_W-1:0] best;

    // Scan downward with >=, so a lower index takes over on an equal value.
    always_comb begin
        found  = 1'b0;
        best   = '0;
        pick_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] >= best)) begin
                found  = 1'b1;
                best   = prio_i[i*PRIO_W +: PRIO_W];
                pick_o = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/slave_port_arbiter.sv
// Module: slave_port_arbiter
// Purpose: grants one slave port to one of N masters. It supports a rotation
//          policy and a programmed fixed-priority policy, plus a per-master
//          elevation that wins over every master that is not elevated.
// Assumes: the grant is held while the owner requests. Mode and priority
//          inputs matter only at an arbitration point. Reset is synchronous
//          and active low.
module slave_port_arbiter #(
    parameter int N      = arb_pkg::NUM_MASTERS,
    parameter int PRIO_W = arb_pkg::PRIO_W,
    parameter int ID_W   = arb_pkg::ID_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        req_i,
    input  logic [N-1:0]        elev_i,
    input  logic                mode_fixed_i,
    input  logic [N*PRIO_W-1:0] prio_cfg_i,
    output logic [N-1:0]        grant_o,
    output logic [ID_W-1:0]     grant_id_o,
    output logic                grant_valid_o
);
    localparam logic [ID_W-1:0] LAST_RESET = ID_W'(N - 1);

    logic            valid_q;
    logic [ID_W-1:0] id_q;
    logic [ID_W-1:0] last_q;
    logic            keep;
    logic            any_req;
    logic [N-1:0]    elev_req;
    logic [N-1:0]    cand;
    logic [ID_W-1:0] rr_pick;
    logic [ID_W-1:0] fx_pick;
    logic [ID_W-1:0] pick;

    // Decide whether to hold the grant, and build the candidate set.
    always_comb begin
        keep     = valid_q && req_i[id_q];
        any_req  = |req_i;
        elev_req = req_i & elev_i;
        cand     = (|elev_req) ? elev_req : req_i;
        pick     = mode_fixed_i ? fx_pick : rr_pick;
    end

    arb_rr_pick #(.N(N), .ID_W(ID_W)) u_rr (
        .cand_i (cand),
        .last_i (last_q),
        .pick_o (rr_pick)
    );

    arb_prio_pick #(.N(N), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_fx (
        .cand_i (cand),
        .prio_i (prio_cfg_i),
        .pick_o (fx_pick)
    );

    // Grant state: hold, take a new winner, or go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            id_q    <= '0;
            last_q  <= LAST_RESET;
        end else if (!keep) begin
            if (any_req) begin
                valid_q <= 1'b1;
                id_q    <= pick;
                last_q  <= pick;
            end else begin
                valid_q <= 1'b0;
                id_q    <= '0;
            end
        end
    end

    // One-hot decode of the registered grant.
    for (genvar g = 0; g < N; g++) begin : g_dec
        assign grant_o[g] = valid_q && (id_q == ID_W'(g));
    end

    assign grant_id_o    = id_q;
    assign grant_valid_o = valid_q;

    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

    assert_granted_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> (($past(req_i) & grant_o) != '0));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && ((req_i & grant_o) != '0)) |=> $stable(grant_o));

    assert_elevated_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(req_i & elev_i)) && !(grant_valid_o && ((req_i & grant_o) != '0)))
            |=> ((grant_o & $past(elev_i)) != '0));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> !grant_valid_o);
endmodule

// File: tb/slave_port_arbiter_bench.sv
module slave_port_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [6:0]   req = '0;
    logic [6:0]   elev = '0;
    logic         mode_fixed = 1'b0;
    logic [20:0]  prio = '0;
    logic [6:0]   grant;
    logic [2:0]   grant_id;
    logic         grant_valid;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slave_port_arbiter u_slave_port_arbiter (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .elev_i        (elev),
        .mode_fixed_i  (mode_fixed),
        .prio_cfg_i    (prio),
        .grant_o       (grant),
        .grant_id_o    (grant_id),
        .grant_valid_o (grant_valid)
    );

    // Advance one edge, then settle away from it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_grant(input bit v, input int id, input string tag);
        logic [6:0] eg;
        logic [2:0] ei;
        eg = v ? (7'b1 << id) : 7'b0;
        ei = v ? 3'(id) : 3'd0;
        checks++;
        if (grant !== eg || grant_id !== ei || grant_valid !== v) begin
            errors++;
            $display("FAIL %s: grant=%b id=%0d valid=%b expected grant=%b id=%0d valid=%b",
                     tag, grant, grant_id, grant_valid, eg, ei, v);
        end
    endtask

    function automatic logic [20:0] pack(input int p0, input int p1, input int p2, input int p3,
                                         input int p4, input int p5, input int p6);
        return {3'(p6), 3'(p5), 3'(p4), 3'(p3), 3'(p2), 3'(p1), 3'(p0)};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; req = '0; elev = '0; mode_fixed = 1'b0; prio = '0;
        step(); step();
        rst_n = 1'b1;
    endtask

    // R5/R1: reset state, then the first rotation grant goes to master 0.
    task automatic t_reset();
        do_reset();
        expect_grant(0, 0, "R5 reset idle");
        req = 7'h7F;
        step();
        expect_grant(1, 0, "R5 first rotation grant");
    endtask

    // R3/R4/R2/R10: hold, advance, wrap, idle.
    task automatic t_rotation();
        step();
        expect_grant(1, 0, "R3 hold while requesting");
        req = 7'h7E; step();
        expect_grant(1, 1, "R4 next after 0");
        req = 7'h7C; step();
        expect_grant(1, 2, "R4 next after 1");
        req = 7'b0000011; step();
        expect_grant(1, 0, "R4 wrap to 0");
        req = 7'b1000011; step();
        expect_grant(1, 0, "R3 others ignored");
        req = '0; step();
        expect_grant(0, 0, "R10 idle");
        req = 7'b1000010; step();
        expect_grant(1, 1, "R2 only requesters");
        req = 7'b1000000; step();
        expect_grant(1, 6, "R4 upward search");
    endtask

    // R6/R7: fixed priority with distinct and equal values.
    task automatic t_fixed();
        do_reset();
        mode_fixed = 1'b1;
        prio = pack(1, 1, 1, 5, 1, 7, 1);
        req = 7'h7F; step();
        expect_grant(1, 5, "R6 largest value");
        req = 7'h5F; step();
        expect_grant(1, 3, "R6 next largest");
        req = '0; step();
        prio = pack(2, 2, 2, 2, 2, 2, 2);
        req = 7'b0010100; step();
        expect_grant(1, 2, "R7 tie lower ID");
    endtask

    // R8: elevation in both modes.
    task automatic t_elevate();
        do_reset();
        mode_fixed = 1'b1;
        prio = pack(0, 3, 3, 3, 3, 3, 7);
        req = 7'b1000001; elev = 7'b0000001; step();
        expect_grant(1, 0, "R8 elevated beats high value");
        do_reset();
        req = 7'h7F; elev = 7'b0100100; step();
        expect_grant(1, 2, "R8 rotation among elevated");
        req = 7'h7B; elev = 7'b0100000; step();
        expect_grant(1, 5, "R8 remaining elevated");
    endtask

    // R9: configuration change during a held grant applies only later.
    task automatic t_midgrant();
        do_reset();
        req = 7'h7F; step();
        expect_grant(1, 0, "R9 rotation owner");
        mode_fixed = 1'b1;
        prio = pack(0, 1, 1, 1, 7, 1, 1);
        step();
        expect_grant(1, 0, "R9 held after mode change");
        step();
        expect_grant(1, 0, "R9 still held");
        req = 7'h7E; step();
        expect_grant(1, 4, "R9 new mode applied");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rotation();
        t_fixed();
        t_elevate();
        t_midgrant();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule